// File: doc/BRIEF.md
# Host Interrupt Collector Register

This block gathers fifteen event sources into one level-sensitive host interrupt line and exposes a single 32-bit control/status word to the host. Six of the sources are handshake bits from three processing elements, two bits each. Each one fires when its bit goes from high to low, after the bit has been resynchronised to the block clock. The other nine sources arrive already in the clock domain and are sampled every cycle. Five of these carry meaning today: step-count done, countdown done, readback done, over-current and DMA done. The remaining four are spare.

The host reads one word that holds the per-source enables and a status field. The status field names every source that contributed to the interrupt now outstanding. A host write does one of two things, chosen by bit 30 of the data. With bit 30 set, the write loads new enables. With bit 30 clear, the write acknowledges the interrupt and leaves the enables alone, so a service routine needs only one write to finish.

A two-state machine drives the interrupt. ST_IDLE means no interrupt is outstanding and the status is zero. ST_PEND means the interrupt line is high. The transitions are named as follows:
- RAISE goes from ST_IDLE to ST_PEND on any enabled event.
- COLLECT stays in ST_PEND and merges in further enabled events.
- CLEAR goes from ST_PEND to ST_IDLE on an acknowledge with no event in that cycle.
- REARM stays in ST_PEND on an acknowledge that coincides with an event. The status then reloads with only that cycle's events.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, irq_o is 0 and rd_data reads 0: all enables are clear and all status bits are clear.
- R2: A write with wr_data[30]=1 loads enables from wr_data[14:0] in the next cycle. Such a write changes neither irq_o nor the status. Without such a write the enables hold their value.
- R3: A write with wr_data[30]=0 leaves the enables unchanged. If no enabled event occurs in that cycle, the write drops irq_o to 0 and clears the status in the next cycle.
- R4: An event whose enable bit is 0 is ignored: irq_o and the status are not affected.
- R5: An enabled clock-domain source j (0..8), driven on evt_i[j], maps to status and enable bit 6+j. A one-cycle pulse on it raises irq_o and sets status bit 6+j in the next cycle.
- R6: Handshake bit b of processing element p is hs_i[2p+b] and maps to source bit 2p+b. A high-to-low transition on it passes two synchroniser flops and an edge flop, so irq_o rises on the third rising clock edge after the change. A rising edge or a steady level raises nothing.
- R7: While the interrupt is outstanding, further enabled events OR into the status. The status therefore lists every source since the interrupt was raised.
- R8: An acknowledge write in the same cycle as an enabled event keeps irq_o at 1. The status then becomes exactly that cycle's enabled events, so the event is not lost.
- R9: The read word is {bit 31 = 0, bit 30 = 0, status in bits 29:15, enables in bits 14:0}. Bit 30 is write-only, and bit 31 is reserved and always reads 0.
- R10: irq_o, once high, stays high until an acknowledge write. A write that loads enables does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_i | input | 6 | Asynchronous handshake bits, index 2p+b |
| evt_i | input | 9 | Clock-domain event requests for sources 6..14 |
| wr_en | input | 1 | Host write strobe for the register |
| wr_data | input | 32 | Host write data; bit 30 selects enable load or acknowledge |
| rd_data | output | 32 | Register read value |
| irq_o | output | 1 | Host interrupt, active high |

## Verification
The hardest situation to create from the ports is an acknowledge that lands in the same cycle as a new enabled event. Both happen in one clock, and the result must differ from a plain clear: the line stays up and the status holds only the newcomer. The stimulus table first raises the interrupt from one source. It then issues the acknowledge write in the same cycle as a pulse from a second enabled source, so the status read afterwards tells the reload apart from both accumulation and clearing. The handshake path is timed separately by watching irq_o on each of the three edges after a falling input.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } irq_state_e;

    localparam int REG_W  = 32;
    localparam int WE_POS = 30;
endpackage

// File: rtl/hirq_hs_edge.sv
module hirq_hs_edge #(
    parameter int N      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hs_async,
    output logic [N-1:0] fall
);
    localparam int PIPE_W = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // pipe[STAGES-1:0] synchronise, pipe[STAGES] holds the previous value
        logic [PIPE_W-1:0] pipe;

        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[PIPE_W-2:0], hs_async[i]};
        end

        assign fall[i] = pipe[STAGES] & ~pipe[STAGES-1];

        // R6
        hs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fall[i] |=> !fall[i]);
    end
endmodule

// File: rtl/hirq_fsm.sv
module hirq_fsm
    import hirq_pkg::*;
#(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         ack,
    output logic         irq,
    output logic [N-1:0] status
);
    irq_state_e  state_q, state_d;
    logic [N-1:0] status_q, status_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            ST_IDLE: begin
                if (|ev) begin          // RAISE
                    state_d  = ST_PEND;
                    status_d = ev;
                end
            end
            ST_PEND: begin
                if (ack) begin
                    if (|ev) begin      // REARM
                        status_d = ev;
                    end else begin      // CLEAR
                        state_d  = ST_IDLE;
                        status_d = '0;
                    end
                end else begin          // COLLECT
                    status_d = status_q | ev;
                end
            end
            default: begin
                state_d  = ST_IDLE;
                status_d = '0;
            end
        endcase
    end

    always_comb begin
        irq    = (state_q == ST_PEND);
        status = status_q;
    end

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack) |=> irq);
    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ev == '0) |=> (!irq && status == '0));
    // R5
    ev_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> (irq && ((status & $past(ev)) == $past(ev))));
    // R8
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack && ev != '0) |=> (irq && status == $past(ev)));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && ev == '0) |=> (!irq && status == '0));
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
    import hirq_pkg::*;
#(
    parameter int NUM_PE    = 3,
    parameter int HS_PER_PE = 2,
    parameter int NUM_SRC   = 15,
    parameter int SYNC_DEP  = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_PE*HS_PER_PE-1:0]            hs_i,
    input  logic [NUM_SRC-NUM_PE*HS_PER_PE-1:0]    evt_i,
    input  logic                                   wr_en,
    input  logic [REG_W-1:0]                       wr_data,
    output logic [REG_W-1:0]                       rd_data,
    output logic                                   irq_o
);
    localparam int NUM_HS   = NUM_PE * HS_PER_PE;
    localparam int STAT_LSB = NUM_SRC;
    localparam int STAT_MSB = 2 * NUM_SRC - 1;

    logic [NUM_HS-1:0]  hs_fall;
    logic [NUM_SRC-1:0] raw_ev, en_q, masked_ev, status;
    logic               en_load, ack;
    logic               unused_wbits;

    hirq_hs_edge #(.N(NUM_HS), .STAGES(SYNC_DEP)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_async (hs_i),
        .fall     (hs_fall)
    );

    assign raw_ev       = {evt_i, hs_fall};
    assign en_load      = wr_en &  wr_data[WE_POS];
    assign ack          = wr_en & ~wr_data[WE_POS];
    assign masked_ev    = raw_ev & en_q;
    assign unused_wbits = ^{wr_data[REG_W-1], wr_data[WE_POS-1:NUM_SRC]};

    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_load) en_q <= wr_data[NUM_SRC-1:0];
    end

    hirq_fsm #(.N(NUM_SRC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (masked_ev),
        .ack    (ack),
        .irq    (irq_o),
        .status (status)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[NUM_SRC-1:0]       = en_q;
        rd_data[STAT_MSB:STAT_LSB] = status;
    end

    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_load |=> (rd_data[NUM_SRC-1:0] == $past(rd_data[NUM_SRC-1:0])));
    // R2
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_load |=> (rd_data[NUM_SRC-1:0] == $past(wr_data[NUM_SRC-1:0])));
endmodule

// File: tb/host_irq_ctrl_bench.sv
module host_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  hs_i = 6'h3F;
    logic [8:0]  evt_i = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    host_irq_ctrl u_host_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hs_i(hs_i), .evt_i(evt_i),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    // {wr, wdata[31:0], evt[8:0], irq, rd[31:0]}
    localparam int VW = 75;
    localparam logic [VW-1:0] VEC [12] = '{
        {1'b1, 32'h40007FC0, 9'h000, 1'b0, 32'h00007FC0}, // R2 load enables 6..14
        {1'b0, 32'h00000000, 9'h001, 1'b1, 32'h00207FC0}, // R5 source 6
        {1'b0, 32'h00000000, 9'h004, 1'b1, 32'h00A07FC0}, // R7 source 8 merges
        {1'b1, 32'hC0007FC0, 9'h000, 1'b1, 32'h00A07FC0}, // R10 R9 enable write keeps irq
        {1'b1, 32'h00000000, 9'h000, 1'b0, 32'h00007FC0}, // R3 acknowledge
        {1'b1, 32'h00001234, 9'h000, 1'b0, 32'h00007FC0}, // R3 enables untouched
        {1'b1, 32'h400000C0, 9'h000, 1'b0, 32'h000000C0}, // R2 enables 6,7
        {1'b0, 32'h00000000, 9'h004, 1'b0, 32'h000000C0}, // R4 source 8 disabled
        {1'b0, 32'h00000000, 9'h001, 1'b1, 32'h002000C0}, // R5 source 6
        {1'b1, 32'h00000000, 9'h002, 1'b1, 32'h004000C0}, // R8 ack with source 7
        {1'b1, 32'h00000000, 9'h000, 1'b0, 32'h000000C0}, // R3 clear
        {1'b0, 32'h00000000, 9'h100, 1'b0, 32'h000000C0}  // R4 source 14 disabled
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic host_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [VW-1:0] v;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 rd", rd_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < 12; k++) begin
            v = VEC[k];
            @(negedge clk);
            wr_en = v[74]; wr_data = v[73:42]; evt_i = v[41:33];
            @(negedge clk);
            wr_en = 1'b0; wr_data = '0; evt_i = '0;
            chk($sformatf("table step %0d irq", k), {31'd0, irq_o}, {31'd0, v[32]});
            chk($sformatf("table step %0d rd", k), rd_data, v[31:0]);
        end

        // R6 handshake timing: enable sources 0..5
        host_write(32'h4000003F);
        hs_i[3] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 no irq after two edges", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        chk("R6 irq on third edge", {31'd0, irq_o}, 32'd1);
        chk("R6 status bit 3", rd_data, 32'h0004003F);
        host_write(32'h00000000);
        chk("R3 ack after handshake", {31'd0, irq_o}, 32'd0);
        hs_i[3] = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6 rising edge ignored", {31'd0, irq_o}, 32'd0);
        hs_i[0] = 1'b0; hs_i[5] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 two falls together", rd_data, 32'h0010803F);
        chk("R9 reserved bits", {30'd0, rd_data[31:30]}, 32'd0);
        summary();
    end
endmodule